// File: doc/BRIEF.md
# Configurable Two-Level Logic Array

This block computes M_OUT Boolean functions of N_IN inputs in sum-of-products form. An AND plane of P_TERMS product terms feeds an OR plane of M_OUT outputs. A small register file, written through an address/data/write-enable port, holds the literal choices for each product term and the set of terms gathered by each output. The outputs are purely combinational from the inputs and the stored configuration.

A two-bit mode input chooses which planes are programmable. In minterm mode the AND plane is a fixed full decoder of the inputs and each output sums whichever minterms its mask selects. In fixed-group mode the literals are programmable, but each output is hard-wired to its own contiguous group of terms. In full mode both planes are programmable, so one term can serve several outputs. The host loads the configuration once, sets the mode, and then uses the outputs as glue logic.

Top module: `sop_logic_array`

## Requirements
- R1: After reset every stored configuration bit is 0, so every output is 0 for every input value in every mode.
- R2: A write with `cfg_we`=1 lands on the rising clock edge. Address k < P_TERMS loads term k: data bits [N_IN-1:0] select true literals (bit i = input i), bits [2*N_IN-1:N_IN] select complemented literals, and bit [2*N_IN] is the empty-term enable. Address P_TERMS+j loads the OR mask of output j (bit k = term k). Before that edge the outputs still reflect the old configuration.
- R3: In fixed-group and full mode a term is the AND of its selected literals: a true literal needs input i = 1, a complemented literal needs input i = 0.
- R4: A term that selects both the true and the complemented literal of the same input is always 0, whatever its enable bit holds.
- R5: A term with no literal selected equals its empty-term enable bit.
- R6: Mode 2'b00 (minterm): term k is 1 exactly when the input value equals k, for k < 2^N_IN. Terms at or above 2^N_IN are 0. The stored literal words have no effect, and output j is the OR of the minterms set in its mask.
- R7: In minterm mode with X = in[2], Y = in[1], Z = in[0], mask {5,6,7} gives XY + XZ and mask {3,5,6,7} gives XY + YZ + XZ.
- R8: Mode 2'b01 (fixed group): output j is the OR of terms j*G to j*G+G-1, with G = P_TERMS/M_OUT. The OR masks have no effect.
- R9: Mode 2'b10 (full): output j is the OR of the terms set in its mask. A term may feed several outputs, so XY + XZ' and XY' + YZ + XZ' fit in four terms.
- R10: Mode 2'b11 drives every output to 0.
- R11: Writes with `cfg_we`=0, and writes to addresses at or above P_TERMS+M_OUT, change no configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration writes |
| rst_n | input | 1 | Asynchronous active-low reset of the configuration |
| mode_sel | input | 2 | Plane mode: 0 minterm, 1 fixed group, 2 full, 3 off |
| in_vec | input | N_IN | Function inputs |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | clog2(P_TERMS+M_OUT) | Configuration word address |
| cfg_data | input | max(2*N_IN+1, P_TERMS) | Configuration write data |
| out_vec | output | M_OUT | Function outputs |

## Verification
The assertion that exactly one minterm fires in minterm mode assumes the inputs are never unknown and that P_TERMS covers all 2^N_IN input values. The bench therefore drives `in_vec` from time zero and uses the default sizes. The reset assertion assumes that no write is presented on the first edge after reset is released. Every bench write waits for a full clock period after release.

// File: rtl/sla_pkg.sv
package sla_pkg;
  typedef enum logic [1:0] {
    MODE_MINTERM = 2'd0,
    MODE_GROUP   = 2'd1,
    MODE_FULL    = 2'd2,
    MODE_OFF     = 2'd3
  } sla_mode_e;
endpackage

// File: rtl/sla_cfg_store.sv
module sla_cfg_store #(
  parameter int N_IN    = 3,
  parameter int P_TERMS = 8,
  parameter int M_OUT   = 2,
  parameter int A_W     = 4,
  parameter int D_W     = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cfg_we,
  input  logic [A_W-1:0]                    cfg_addr,
  input  logic [D_W-1:0]                    cfg_data,
  output logic [P_TERMS-1:0][N_IN-1:0]      true_mask,
  output logic [P_TERMS-1:0][N_IN-1:0]      comp_mask,
  output logic [P_TERMS-1:0]                empty_en,
  output logic [M_OUT-1:0][P_TERMS-1:0]     or_mask
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      true_mask <= '0;
      comp_mask <= '0;
      empty_en  <= '0;
      or_mask   <= '0;
    end else if (cfg_we) begin
      for (int k = 0; k < P_TERMS; k++) begin
        if (cfg_addr == A_W'(k)) begin
          true_mask[k] <= cfg_data[N_IN-1:0];
          comp_mask[k] <= cfg_data[2*N_IN-1:N_IN];
          empty_en[k]  <= cfg_data[2*N_IN];
        end
      end
      for (int j = 0; j < M_OUT; j++) begin
        if (cfg_addr == A_W'(P_TERMS + j)) begin
          or_mask[j] <= cfg_data[P_TERMS-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/sla_and_plane.sv
module sla_and_plane
  import sla_pkg::*;
#(
  parameter int N_IN    = 3,
  parameter int P_TERMS = 8
) (
  input  sla_mode_e                     mode,
  input  logic [N_IN-1:0]               in_vec,
  input  logic [P_TERMS-1:0][N_IN-1:0]  true_mask,
  input  logic [P_TERMS-1:0][N_IN-1:0]  comp_mask,
  input  logic [P_TERMS-1:0]            empty_en,
  output logic [P_TERMS-1:0]            term_vec
);
  localparam int MINTERMS = 2 ** N_IN;

  // Programmable product: empty terms follow their enable, otherwise AND of literals.
  function automatic logic eval_term(input logic [N_IN-1:0] x,
                                     input logic [N_IN-1:0] t,
                                     input logic [N_IN-1:0] c,
                                     input logic            en);
    if ((t | c) == '0) return en;
    return &((~t | x) & (~c | ~x));
  endfunction

  logic [P_TERMS-1:0] prog_term;
  logic [P_TERMS-1:0] dec_term;

  for (genvar k = 0; k < P_TERMS; k++) begin : g_term
    assign prog_term[k] = eval_term(in_vec, true_mask[k], comp_mask[k], empty_en[k]);
    if (k < MINTERMS) begin : g_dec
      assign dec_term[k] = (in_vec == N_IN'(k));
    end else begin : g_nodec
      assign dec_term[k] = 1'b0;
    end
  end

  assign term_vec = (mode == MODE_MINTERM) ? dec_term : prog_term;
endmodule

// File: rtl/sla_or_plane.sv
module sla_or_plane
  import sla_pkg::*;
#(
  parameter int P_TERMS = 8,
  parameter int M_OUT   = 2
) (
  input  sla_mode_e                      mode,
  input  logic [P_TERMS-1:0]             term_vec,
  input  logic [M_OUT-1:0][P_TERMS-1:0]  or_mask,
  output logic [M_OUT-1:0]               out_vec
);
  localparam int GRP = P_TERMS / M_OUT;

  // Fixed term group owned by output j in fixed-group mode.
  function automatic logic [P_TERMS-1:0] group_mask(input int j);
    logic [P_TERMS-1:0] m;
    m = '0;
    for (int k = 0; k < P_TERMS; k++) begin
      if (k >= j * GRP && k < (j + 1) * GRP) m[k] = 1'b1;
    end
    return m;
  endfunction

  for (genvar j = 0; j < M_OUT; j++) begin : g_out
    localparam logic [P_TERMS-1:0] GMASK = group_mask(j);
    logic prog_sum;
    logic grp_sum;
    assign prog_sum = |(term_vec & or_mask[j]);
    assign grp_sum  = |(term_vec & GMASK);
    always_comb begin
      unique case (mode)
        MODE_MINTERM, MODE_FULL: out_vec[j] = prog_sum;
        MODE_GROUP:              out_vec[j] = grp_sum;
        default:                 out_vec[j] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/sop_logic_array.sv
module sop_logic_array
  import sla_pkg::*;
#(
  parameter int N_IN    = 3,
  parameter int P_TERMS = 8,
  parameter int M_OUT   = 2,
  localparam int TERM_W = 2 * N_IN + 1,
  localparam int CFG_W  = (TERM_W > P_TERMS) ? TERM_W : P_TERMS,
  localparam int ADDR_W = $clog2(P_TERMS + M_OUT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_sel,
  input  logic [N_IN-1:0]   in_vec,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CFG_W-1:0]  cfg_data,
  output logic [M_OUT-1:0]  out_vec
);
  sla_mode_e                     mode_e;
  logic [P_TERMS-1:0][N_IN-1:0]  true_mask;
  logic [P_TERMS-1:0][N_IN-1:0]  comp_mask;
  logic [P_TERMS-1:0]            empty_en;
  logic [M_OUT-1:0][P_TERMS-1:0] or_mask;
  logic [P_TERMS-1:0]            term_vec;

  assign mode_e = sla_mode_e'(mode_sel);

  sla_cfg_store #(
    .N_IN(N_IN), .P_TERMS(P_TERMS), .M_OUT(M_OUT), .A_W(ADDR_W), .D_W(CFG_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .true_mask(true_mask), .comp_mask(comp_mask),
    .empty_en(empty_en), .or_mask(or_mask)
  );

  sla_and_plane #(.N_IN(N_IN), .P_TERMS(P_TERMS)) u_and (
    .mode(mode_e), .in_vec(in_vec), .true_mask(true_mask),
    .comp_mask(comp_mask), .empty_en(empty_en), .term_vec(term_vec)
  );

  sla_or_plane #(.P_TERMS(P_TERMS), .M_OUT(M_OUT)) u_or (
    .mode(mode_e), .term_vec(term_vec), .or_mask(or_mask), .out_vec(out_vec)
  );
endmodule

// File: rtl/sla_chk.sv
module sla_chk #(
  parameter int N_IN    = 3,
  parameter int P_TERMS = 8,
  parameter int M_OUT   = 2,
  localparam int ADDR_W = $clog2(P_TERMS + M_OUT)
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic [1:0]                       mode_sel,
  input logic                             cfg_we,
  input logic [ADDR_W-1:0]                cfg_addr,
  input logic [N_IN-1:0]                  cfg_true_bits,
  input logic [P_TERMS-1:0][N_IN-1:0]     true_mask,
  input logic [P_TERMS-1:0][N_IN-1:0]     comp_mask,
  input logic [P_TERMS-1:0]               term_vec,
  input logic [M_OUT-1:0]                 out_vec
);
  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> out_vec == '0); // R1

  AST_PROM_ONE_MINTERM: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sel == 2'd0 |-> $countones(term_vec) == 1); // R6

  AST_NO_TERM_NO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    term_vec == '0 |-> out_vec == '0); // R9

  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sel == 2'd3 |-> out_vec == '0); // R10

  AST_BAD_ADDR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && ({1'b0, cfg_addr} >= (ADDR_W+1)'(P_TERMS + M_OUT))
    |=> $stable(true_mask) && $stable(comp_mask)); // R11

  for (genvar k = 0; k < P_TERMS; k++) begin : g_term_chk
    AST_TERM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we && cfg_addr == ADDR_W'(k) |=> true_mask[k] == $past(cfg_true_bits)); // R2

    AST_CONFLICT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      mode_sel != 2'd0 && (true_mask[k] & comp_mask[k]) != '0 |-> !term_vec[k]); // R4
  end
endmodule

bind sop_logic_array sla_chk #(.N_IN(N_IN), .P_TERMS(P_TERMS), .M_OUT(M_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cfg_we(cfg_we),
  .cfg_addr(cfg_addr), .cfg_true_bits(cfg_data[N_IN-1:0]),
  .true_mask(true_mask), .comp_mask(comp_mask), .term_vec(term_vec),
  .out_vec(out_vec)
);

// File: tb/sop_logic_array_tb.sv
`timescale 1ns/1ps
module sop_logic_array_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_sel = 2'd2;
  logic [2:0] in_vec = 3'd0;
  logic       cfg_we = 1'b0;
  logic [3:0] cfg_addr = 4'd0;
  logic [7:0] cfg_data = 8'd0;
  logic [1:0] out_vec;
  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  sop_logic_array u_dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .in_vec(in_vec),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data), .out_vec(out_vec)
  );

  task automatic chk(input string tag, input logic [1:0] got, input logic [1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: in=%0d mode=%0d got %b expected %b", tag, in_vec, mode_sel, got, exp);
    end
  endtask

  task automatic do_reset();
    cfg_we = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic apply(input logic [2:0] v);
    @(negedge clk);
    in_vec = v;
    #1;
  endtask

  // Shared-term example: t0=XY t1=XZ' t2=XY' t3=YZ; A uses t0,t1; B uses t1,t2,t3
  task automatic load_shared();
    wr(4'd0, 8'h06); wr(4'd1, 8'h0C); wr(4'd2, 8'h14); wr(4'd3, 8'h03);
    wr(4'd8, 8'b0000_0011); wr(4'd9, 8'b0000_1110);
  endtask

  task automatic t_reset();
    do_reset();
    for (int m = 0; m < 4; m++) begin
      mode_sel = 2'(m);
      for (int v = 0; v < 8; v++) begin apply(3'(v)); chk("R1 reset", out_vec, 2'b00); end
    end
    mode_sel = 2'd2; load_shared(); do_reset();
    for (int v = 0; v < 8; v++) begin apply(3'(v)); chk("R1 re-reset", out_vec, 2'b00); end
  endtask

  task automatic t_write_timing();
    do_reset(); mode_sel = 2'd2;
    wr(4'd0, 8'h40);
    apply(3'd5);
    cfg_we = 1'b1; cfg_addr = 4'd8; cfg_data = 8'h01;
    #1; chk("R2 before edge", out_vec, 2'b00);
    @(posedge clk); #1; cfg_we = 1'b0;
    chk("R2 after edge", out_vec, 2'b01);
  endtask

  task automatic t_literals();
    do_reset(); mode_sel = 2'd2;
    wr(4'd0, 8'h21); wr(4'd8, 8'h01);           // Z & ~X
    for (int v = 0; v < 8; v++) begin
      logic x, z;
      apply(3'(v)); x = v[2]; z = v[0];
      chk("R3 literals", out_vec, {1'b0, z & ~x});
    end
  endtask

  task automatic t_conflict();
    do_reset(); mode_sel = 2'd2;
    wr(4'd0, 8'h49); wr(4'd8, 8'h01);           // Z and ~Z, enable set
    for (int v = 0; v < 8; v++) begin apply(3'(v)); chk("R4 conflict", out_vec, 2'b00); end
    mode_sel = 2'd1;
    for (int v = 0; v < 8; v++) begin apply(3'(v)); chk("R4 conflict group", out_vec, 2'b00); end
  endtask

  task automatic t_empty();
    do_reset(); mode_sel = 2'd2;
    wr(4'd0, 8'h40); wr(4'd8, 8'h01);
    for (int v = 0; v < 8; v++) begin apply(3'(v)); chk("R5 empty on", out_vec, 2'b01); end
    wr(4'd0, 8'h00);
    for (int v = 0; v < 8; v++) begin apply(3'(v)); chk("R5 empty off", out_vec, 2'b00); end
  endtask

  task automatic t_prom();
    do_reset(); mode_sel = 2'd0;
    for (int k = 0; k < 8; k++) wr(4'(k), 8'h40);   // literal words must not matter
    wr(4'd8, 8'b1110_0000); wr(4'd9, 8'b1110_1000);
    for (int v = 0; v < 8; v++) begin
      logic x, y, z;
      apply(3'(v)); x = v[2]; y = v[1]; z = v[0];
      chk("R7 minterm example", out_vec, {(x&y)|(y&z)|(x&z), (x&y)|(x&z)});
    end
    wr(4'd8, 8'b0000_0001); wr(4'd9, 8'b0001_0000);
    for (int v = 0; v < 8; v++) begin
      apply(3'(v));
      chk("R6 single minterms", out_vec, {v == 4, v == 0});
    end
  endtask

  task automatic t_pal();
    do_reset(); mode_sel = 2'd1;
    wr(4'd0, 8'h06); wr(4'd1, 8'h0C); wr(4'd4, 8'h14); wr(4'd5, 8'h03);
    wr(4'd8, 8'h00); wr(4'd9, 8'hFF);                // OR masks must not matter
    for (int v = 0; v < 8; v++) begin
      logic x, y, z;
      apply(3'(v)); x = v[2]; y = v[1]; z = v[0];
      chk("R8 fixed groups", out_vec, {(x&~y)|(y&z), (x&y)|(x&~z)});
    end
  endtask

  task automatic t_pla();
    do_reset(); mode_sel = 2'd2; load_shared();
    for (int v = 0; v < 8; v++) begin
      logic x, y, z;
      apply(3'(v)); x = v[2]; y = v[1]; z = v[0];
      chk("R9 shared term", out_vec, {(x&~y)|(y&z)|(x&~z), (x&y)|(x&~z)});
    end
  endtask

  task automatic t_off();
    do_reset(); mode_sel = 2'd2; load_shared(); mode_sel = 2'd3;
    for (int v = 0; v < 8; v++) begin apply(3'(v)); chk("R10 off mode", out_vec, 2'b00); end
  endtask

  task automatic t_ignored();
    do_reset();
    for (int a = 10; a < 16; a++) wr(4'(a), 8'hFF);
    @(negedge clk); cfg_addr = 4'd0; cfg_data = 8'h40;   // we stays low
    @(negedge clk); cfg_addr = 4'd8; cfg_data = 8'h01;
    @(negedge clk);
    for (int m = 0; m < 3; m++) begin
      mode_sel = 2'(m);
      for (int v = 0; v < 8; v++) begin apply(3'(v)); chk("R11 ignored writes", out_vec, 2'b00); end
    end
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_write_timing();
    t_literals();
    t_conflict();
    t_empty();
    t_prom();
    t_pal();
    t_pla();
    t_off();
    t_ignored();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule